// File: doc/BRIEF.md
# Flash Program and Sector-Erase Command Sequencer

This block drives a parallel NOR-style flash device from the host side. It takes one request at a time, either a byte program or an erase of one or more sectors. It issues the unlock and command writes the device expects, then decides when the device has finished by reading status bytes in pairs and comparing the toggle bit. The outcome is reported on a result stream: success, failure or timeout. On failure or timeout the device is first returned to array-read mode with a reset write.

The request side and the result side are valid/ready streams. A request is taken on the cycle that `req_valid` and `req_ready` are both high, and `req_ready` stays low until the result of that request has been handed over. The result is held stable, together with its flags, until `res_ready` is seen high with `res_valid`, so a slow consumer simply stalls the sequencer in its report state. The device side is a plain synchronous bus. The sequencer raises `bus_req` and holds the access fields until the device answers with a one-cycle `bus_ack`. For a read, `bus_rdata` is taken in the `bus_ack` cycle.

For a multi-sector erase, the sequencer reads the sector-load window bit before and after each extra sector load. A closed window before a load skips the remaining loads. A closed window after a load marks that load as possibly lost. Either case sets the result's load-miss flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: `req_ready` is high only when no request is in progress, and `busy` is high from acceptance until the result handshake. A `req_valid` held high during an operation starts nothing and causes no bus access.
- R2: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged on the next cycle. Each access ends on its `bus_ack` cycle.
- R3: A program request (`req_erase`=0) issues exactly four writes, as (address, data): (555h,AAh), (2AAh,55h), (555h,A0h), then (`req_addr`,`req_data`).
- R4: An erase request (`req_erase`=1) issues six writes: (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), then (first sector,30h). Each further sector in the list, up to `req_sec_cnt` sectors with 0 treated as 1 and values above MAX_SECT clamped to MAX_SECT, is loaded with a write of 30h at that sector's address. Sector k occupies bits [k*AW +: AW] of `req_sec_list`.
- R5: Each extra sector load is preceded and followed by a status read. Bit 3 at 1 on the read before a load ends all loading without writing. Bit 3 at 1 on the read after a load does not end loading. Either case sets `res_load_miss`.
- R6: Status polling reads at the target address for a program, or at the first sector address for an erase, in pairs and issues no write. If bit 6 is equal in both reads, the result is success (`res_code`=0).
- R7: If bit 6 differs in a pair and bit 5 of the second read is 1, one more pair is read. If bit 6 then matches, the result is success; otherwise it is failure (`res_code`=1).
- R8: If bit 6 differs and bit 5 of the second read is 0, polling continues. After MAX_POLLS such pairs with no completion, the result is timeout (`res_code`=2).
- R9: On failure or timeout, a write of F0h at address 0 is issued before `res_valid` rises, and no such write happens on success. `res_valid`, `res_code` and `res_load_miss` hold until `res_ready` is high.
- R10: After reset `req_ready` is 1, and `busy`, `bus_req` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr | input | AW | Program target address |
| req_data | input | DW | Program data |
| req_sec_list | input | MAX_SECT*AW | Packed sector addresses, sector 0 lowest |
| req_sec_cnt | input | $clog2(MAX_SECT+1) | Number of sectors to erase |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_code | output | 2 | 0 success, 1 failure, 2 timeout |
| res_load_miss | output | 1 | A sector load may not have been taken |
| busy | output | 1 | A request is in progress |
| bus_req | output | 1 | Device access requested |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
Assertions check the bus hold rule, the single-outstanding-access rule, read-only behaviour while polling, the bound on the poll counter, the quiet bus while idle, the stable result under back-pressure and the reset write on every failed result, all on every cycle. Only the bench's scenarios can show the exact write sequences for program and erase, the branch taken after each pair of status reads, the skip and flag behaviour of the sector-load window, and the timeout after the configured number of pairs. The bench does this against a device model that returns scripted status bytes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_PRE, S_LOAD, S_POST, S_PA, S_PB, S_RST, S_RPT
  } seq_state_t;

  typedef enum logic [2:0] {
    V_OK, V_FAIL, V_RECHK, V_AGAIN, V_TMO
  } verdict_t;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;

  localparam logic [10:0] ADR_KEY1 = 11'h555;
  localparam logic [10:0] ADR_KEY2 = 11'h2AA;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] SET_PROG   = 8'hA0;
  localparam logic [7:0] SET_ERASE  = 8'h80;
  localparam logic [7:0] SECT_LOAD  = 8'h30;
  localparam logic [7:0] DEV_RESET  = 8'hF0;

  localparam int TGL_BIT = 6;
  localparam int LIM_BIT = 5;
  localparam int WIN_BIT = 3;

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          erase,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  input  logic [AW-1:0] sec0,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          last
);
  localparam logic [AW-1:0] A_K1 = AW'(ADR_KEY1);
  localparam logic [AW-1:0] A_K2 = AW'(ADR_KEY2);

  always_comb begin
    case (step)
      3'd0: begin wr_addr = A_K1; wr_data = DW'(KEY_FIRST);  end
      3'd1: begin wr_addr = A_K2; wr_data = DW'(KEY_SECOND); end
      3'd2: begin
        wr_addr = A_K1;
        wr_data = erase ? DW'(SET_ERASE) : DW'(SET_PROG);
      end
      3'd3: begin
        wr_addr = erase ? A_K1 : tgt_addr;
        wr_data = erase ? DW'(KEY_FIRST) : tgt_data;
      end
      3'd4: begin wr_addr = A_K2; wr_data = DW'(KEY_SECOND); end
      default: begin wr_addr = sec0; wr_data = DW'(SECT_LOAD); end
    endcase
    last = erase ? (step == 3'd5) : (step == 3'd3);
  end

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_seq_pkg::*;
(
  input  logic     tgl_first,
  input  logic     tgl_second,
  input  logic     lim_second,
  input  logic     rechk,
  input  logic     exhaust,
  output verdict_t verdict
);
  logic stopped;

  always_comb begin
    stopped = (tgl_first == tgl_second);
    if (stopped)         verdict = V_OK;
    else if (rechk)      verdict = V_FAIL;
    else if (lim_second) verdict = V_RECHK;
    else if (exhaust)    verdict = V_TMO;
    else                 verdict = V_AGAIN;
  end

endmodule

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          fin,
  output logic [DW-1:0] rdata_q,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      fin       <= 1'b0;
      rdata_q   <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      fin <= 1'b0;
      if (!active && go) begin
        active    <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end else if (active && bus_ack) begin
        active  <= 1'b0;
        fin     <= 1'b1;
        rdata_q <= bus_rdata;
      end
    end
  end

  assign bus_req = active;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R2
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !bus_req && !fin); // R2

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int MAX_SECT  = 4,
  parameter int MAX_POLLS = 64,
  localparam int CW = $clog2(MAX_SECT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_erase,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_data,
  input  logic [MAX_SECT*AW-1:0] req_sec_list,
  input  logic [CW-1:0]          req_sec_cnt,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [1:0]             res_code,
  output logic                   res_load_miss,
  output logic                   busy,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [AW-1:0]          bus_addr,
  output logic [DW-1:0]          bus_wdata,
  input  logic [DW-1:0]          bus_rdata,
  input  logic                   bus_ack
);
  localparam int IW = $clog2(MAX_SECT);
  localparam int PW = $clog2(MAX_POLLS + 1);

  seq_state_t      state;
  logic            erase_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   sec_q [MAX_SECT];
  logic [AW-1:0]   sec_in [MAX_SECT];
  logic [CW-1:0]   sec_cnt_q;
  logic [CW-1:0]   sec_idx;
  logic [2:0]      step;
  logic            pend;
  logic            tgl_a;
  logic            rechk;
  logic [PW-1:0]   poll_cnt;
  logic [1:0]      code_q;
  logic            miss_q;
  logic            rst_sent;

  logic            acc_need, acc_we, go, fin;
  logic [AW-1:0]   acc_addr;
  logic [DW-1:0]   acc_wdata;
  logic [DW-1:0]   rd_q;
  logic [AW-1:0]   tbl_addr;
  logic [DW-1:0]   tbl_data;
  logic            tbl_last;
  logic [AW-1:0]   poll_addr;
  logic            more_sect;
  verdict_t        verdict;

  for (genvar g = 0; g < MAX_SECT; g++) begin : g_unpack
    assign sec_in[g] = req_sec_list[g*AW +: AW];
  end

  flash_cmd_table #(.AW(AW), .DW(DW)) u_table (
    .erase    (erase_q),
    .step     (step),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .sec0     (sec_q[0]),
    .wr_addr  (tbl_addr),
    .wr_data  (tbl_data),
    .last     (tbl_last)
  );

  flash_poll_judge u_judge (
    .tgl_first  (tgl_a),
    .tgl_second (rd_q[TGL_BIT]),
    .lim_second (rd_q[LIM_BIT]),
    .rechk      (rechk),
    .exhaust    (poll_cnt == PW'(MAX_POLLS - 1)),
    .verdict    (verdict)
  );

  flash_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_we     (acc_we),
    .go_addr   (acc_addr),
    .go_wdata  (acc_wdata),
    .fin       (fin),
    .rdata_q   (rd_q),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );

  assign poll_addr = erase_q ? sec_q[0] : addr_q;
  assign more_sect = (sec_idx + CW'(1)) < sec_cnt_q;

  always_comb begin
    acc_need  = 1'b1;
    acc_we    = 1'b0;
    acc_addr  = poll_addr;
    acc_wdata = '0;
    case (state)
      S_CMD: begin
        acc_we = 1'b1; acc_addr = tbl_addr; acc_wdata = tbl_data;
      end
      S_LOAD: begin
        acc_we = 1'b1; acc_addr = sec_q[sec_idx[IW-1:0]]; acc_wdata = DW'(SECT_LOAD);
      end
      S_RST: begin
        acc_we = 1'b1; acc_addr = '0; acc_wdata = DW'(DEV_RESET);
      end
      S_PRE, S_POST, S_PA, S_PB: acc_need = 1'b1;
      default: acc_need = 1'b0;
    endcase
  end

  assign go = acc_need && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      erase_q   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      sec_cnt_q <= '0;
      sec_idx   <= '0;
      step      <= '0;
      pend      <= 1'b0;
      tgl_a     <= 1'b0;
      rechk     <= 1'b0;
      poll_cnt  <= '0;
      code_q    <= RES_OK;
      miss_q    <= 1'b0;
      rst_sent  <= 1'b0;
      for (int i = 0; i < MAX_SECT; i++) sec_q[i] <= '0;
    end else begin
      if (go)       pend <= 1'b1;
      else if (fin) pend <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          erase_q   <= req_erase;
          addr_q    <= req_addr;
          data_q    <= req_data;
          sec_cnt_q <= (req_sec_cnt > CW'(MAX_SECT)) ? CW'(MAX_SECT) : req_sec_cnt;
          for (int i = 0; i < MAX_SECT; i++) sec_q[i] <= sec_in[i];
          sec_idx   <= CW'(1);
          step      <= '0;
          rechk     <= 1'b0;
          poll_cnt  <= '0;
          miss_q    <= 1'b0;
          rst_sent  <= 1'b0;
          state     <= S_CMD;
        end
        S_CMD: if (fin) begin
          if (tbl_last)
            state <= (erase_q && (sec_idx < sec_cnt_q)) ? S_PRE : S_PA;
          else
            step <= step + 3'd1;
        end
        S_PRE: if (fin) begin
          if (rd_q[WIN_BIT]) begin
            miss_q <= 1'b1;
            state  <= S_PA;
          end else begin
            state  <= S_LOAD;
          end
        end
        S_LOAD: if (fin) state <= S_POST;
        S_POST: if (fin) begin
          if (rd_q[WIN_BIT]) miss_q <= 1'b1;
          sec_idx <= sec_idx + CW'(1);
          state   <= more_sect ? S_PRE : S_PA;
        end
        S_PA: if (fin) begin
          tgl_a <= rd_q[TGL_BIT];
          state <= S_PB;
        end
        S_PB: if (fin) begin
          case (verdict)
            V_OK:    begin code_q <= RES_OK;   state <= S_RPT; end
            V_FAIL:  begin code_q <= RES_FAIL; state <= S_RST; end
            V_TMO:   begin code_q <= RES_TMO;  state <= S_RST; end
            V_RECHK: begin rechk <= 1'b1;      state <= S_PA;  end
            default: begin poll_cnt <= poll_cnt + PW'(1); state <= S_PA; end
          endcase
        end
        S_RST: if (fin) begin
          rst_sent <= 1'b1;
          state    <= S_RPT;
        end
        S_RPT: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign busy          = (state != S_IDLE);
  assign res_valid     = (state == S_RPT);
  assign res_code      = code_q;
  assign res_load_miss = miss_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req); // R1
  AST_POLL_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PA || state == S_PB) && bus_req |-> !bus_we); // R6
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PW'(MAX_POLLS)); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_load_miss)); // R9
  AST_RESET_BEFORE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_code != RES_OK) |-> rst_sent); // R9

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int MS = 4;
  localparam int MP = 4;
  localparam int CW = $clog2(MS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 1'b0, req_ready, req_erase = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [DW-1:0]    req_data = '0;
  logic [MS*AW-1:0] req_sec_list = '0;
  logic [CW-1:0]    req_sec_cnt = '0;
  logic             res_valid, res_ready = 1'b0, res_load_miss, busy;
  logic [1:0]       res_code;
  logic             bus_req, bus_we, bus_ack;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata, bus_rdata;

  flash_cmd_seq #(.AW(AW), .DW(DW), .MAX_SECT(MS), .MAX_POLLS(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
    .req_sec_list(req_sec_list), .req_sec_cnt(req_sec_cnt),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
    .res_load_miss(res_load_miss), .busy(busy), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // device model: one-cycle ack, logs writes, returns scripted status reads
  logic [7:0]    script [32];
  int            rd_len = 0;
  logic          log_clr = 1'b0;
  logic [AW-1:0] wr_a [32];
  logic [DW-1:0] wr_d [32];
  int            wr_n = 0;
  int            rd_n = 0;
  logic          ack_r = 1'b0;
  logic [DW-1:0] rdata_r = '0;
  assign bus_ack   = ack_r;
  assign bus_rdata = rdata_r;

  always @(posedge clk) begin
    if (!rst_n || log_clr) begin
      ack_r <= 1'b0;
      wr_n  <= 0;
      rd_n  <= 0;
    end else begin
      ack_r <= 1'b0;
      if (bus_req && !ack_r) begin
        ack_r <= 1'b1;
        if (bus_we) begin
          if (wr_n < 32) begin wr_a[wr_n] <= bus_addr; wr_d[wr_n] <= bus_wdata; end
          wr_n <= wr_n + 1;
        end else begin
          rdata_r <= (rd_n < rd_len) ? script[rd_n] : 8'h00;
          rd_n <= rd_n + 1;
        end
      end
    end
  end

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_log();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  // issue a request and wait for the result; hold keeps req_valid high meanwhile
  task automatic run_op(input bit erase, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [MS*AW-1:0] secs, input int cnt, input bit hold);
    int n;
    clear_log();
    req_erase = erase; req_addr = a; req_data = d;
    req_sec_list = secs; req_sec_cnt = CW'(cnt);
    req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    chk(busy && !req_ready, "R1 busy after accept", {busy, req_ready}, 2'b10);
    if (hold) begin
      req_addr = a + 19'h100;
      req_data = ~d;
    end
    n = 0;
    while (!res_valid && n < 2000) begin @(negedge clk); n++; end
    chk(res_valid, "R9 result arrives", res_valid, 1);
    req_valid = 1'b0;
  endtask

  task automatic take_result();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(req_ready && !busy, "R1 idle after result", {req_ready, busy}, 2'b10);
  endtask

  task automatic chk_prog_writes(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    chk(wr_a[0] == 19'h555 && wr_d[0] == 8'hAA, tag, {wr_a[0], wr_d[0]}, {19'h555, 8'hAA});
    chk(wr_a[1] == 19'h2AA && wr_d[1] == 8'h55, tag, {wr_a[1], wr_d[1]}, {19'h2AA, 8'h55});
    chk(wr_a[2] == 19'h555 && wr_d[2] == 8'hA0, tag, {wr_a[2], wr_d[2]}, {19'h555, 8'hA0});
    chk(wr_a[3] == a && wr_d[3] == d, tag, {wr_a[3], wr_d[3]}, {a, d});
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
    chk(!busy && !bus_req && !res_valid, "R10 quiet", {busy, bus_req, res_valid}, 0);
  endtask

  task automatic t_prog_ok();
    script[0] = 8'h40; script[1] = 8'h40; rd_len = 2;
    run_op(1'b0, 19'h12345, 8'h5A, '0, 0, 1'b0);
    chk(wr_n == 4, "R3 write count", wr_n, 4);
    chk_prog_writes(19'h12345, 8'h5A, "R3 program write");
    chk(res_code == 2'd0, "R6 success code", res_code, 0);
    chk(rd_n == 2, "R6 one read pair", rd_n, 2);
    take_result();
  endtask

  task automatic t_prog_poll_more();
    script[0] = 8'h40; script[1] = 8'h00; script[2] = 8'h00; script[3] = 8'h40;
    script[4] = 8'h00; script[5] = 8'h00; rd_len = 6;
    run_op(1'b0, 19'h00777, 8'hC3, '0, 0, 1'b1);
    chk(wr_n == 4, "R1 held request ignored", wr_n, 4);
    chk_prog_writes(19'h00777, 8'hC3, "R1 first request kept");
    chk(rd_n == 6, "R8 polling continues", rd_n, 6);
    chk(res_code == 2'd0, "R8 success after toggles", res_code, 0);
    take_result();
  endtask

  task automatic t_prog_recheck_ok();
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h20; rd_len = 4;
    run_op(1'b0, 19'h00010, 8'h11, '0, 0, 1'b0);
    chk(rd_n == 4, "R7 recheck pair read", rd_n, 4);
    chk(res_code == 2'd0, "R7 recheck success", res_code, 0);
    chk(wr_n == 4, "R9 no reset on success", wr_n, 4);
    take_result();
  endtask

  task automatic t_prog_fail();
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h60; rd_len = 4;
    run_op(1'b0, 19'h00020, 8'h22, '0, 0, 1'b0);
    chk(res_code == 2'd1, "R7 failure code", res_code, 1);
    chk(wr_n == 5, "R9 reset write issued", wr_n, 5);
    chk(wr_a[4] == '0 && wr_d[4] == 8'hF0, "R9 reset write value", {wr_a[4], wr_d[4]}, {19'h0, 8'hF0});
    repeat (3) @(negedge clk);
    chk(res_valid && res_code == 2'd1, "R9 result held", {res_valid, res_code}, 3'b101);
    take_result();
  endtask

  task automatic t_timeout();
    for (int i = 0; i < 2*MP; i++) script[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
    rd_len = 2*MP + 4;
    for (int i = 2*MP; i < 2*MP + 4; i++) script[i] = 8'h00;
    run_op(1'b0, 19'h00030, 8'h33, '0, 0, 1'b0);
    chk(res_code == 2'd2, "R8 timeout code", res_code, 2);
    chk(rd_n == 2*MP, "R8 pair limit", rd_n, 2*MP);
    chk(wr_n == 5 && wr_d[4] == 8'hF0, "R9 reset after timeout", wr_d[4], 8'hF0);
    take_result();
  endtask

  task automatic t_erase_one();
    logic [MS*AW-1:0] s = '0;
    s[0 +: AW] = 19'h40000;
    script[0] = 8'h80; script[1] = 8'h80; rd_len = 2;
    run_op(1'b1, '0, '0, s, 1, 1'b0);
    chk(wr_n == 6, "R4 erase write count", wr_n, 6);
    chk(wr_d[2] == 8'h80 && wr_a[3] == 19'h555 && wr_d[3] == 8'hAA && wr_a[4] == 19'h2AA,
        "R4 erase unlock", {wr_d[2], wr_d[3]}, {8'h80, 8'hAA});
    chk(wr_a[5] == 19'h40000 && wr_d[5] == 8'h30, "R4 first sector load", {wr_a[5], wr_d[5]}, {19'h40000, 8'h30});
    chk(res_code == 2'd0 && !res_load_miss, "R6 erase success", {res_code, res_load_miss}, 0);
    take_result();
  endtask

  task automatic t_erase_multi();
    logic [MS*AW-1:0] s = '0;
    s[0 +: AW] = 19'h10000; s[AW +: AW] = 19'h20000; s[2*AW +: AW] = 19'h30000;
    script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h00; script[3] = 8'h00;
    script[4] = 8'h80; script[5] = 8'h80; rd_len = 6;
    run_op(1'b1, '0, '0, s, 3, 1'b0);
    chk(wr_n == 8, "R4 extra loads", wr_n, 8);
    chk(wr_a[6] == 19'h20000 && wr_d[6] == 8'h30, "R4 second sector", wr_a[6], 19'h20000);
    chk(wr_a[7] == 19'h30000 && wr_d[7] == 8'h30, "R4 third sector", wr_a[7], 19'h30000);
    chk(rd_n == 6, "R5 window reads", rd_n, 6);
    chk(!res_load_miss, "R5 no miss", res_load_miss, 0);
    take_result();
  endtask

  task automatic t_erase_window();
    logic [MS*AW-1:0] s = '0;
    s[0 +: AW] = 19'h10000; s[AW +: AW] = 19'h20000; s[2*AW +: AW] = 19'h30000;
    script[0] = 8'h00; script[1] = 8'h08; script[2] = 8'h08;
    script[3] = 8'h80; script[4] = 8'h80; rd_len = 5;
    run_op(1'b1, '0, '0, s, 3, 1'b0);
    chk(wr_n == 7, "R5 closed window skips load", wr_n, 7);
    chk(rd_n == 5, "R5 read count", rd_n, 5);
    chk(res_load_miss, "R5 miss flagged", res_load_miss, 1);
    chk(res_code == 2'd0, "R5 erase still succeeds", res_code, 0);
    take_result();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_ok();
    t_prog_poll_more();
    t_prog_recheck_ok();
    t_prog_fail();
    t_timeout();
    t_erase_one();
    t_erase_multi();
    t_erase_window();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule